// File: doc/BRIEF.md
# Deficit-Surplus Batch Packet Dispatcher

This block assigns a stream of variable-length packets to a set of worker ports in repeating rounds. Each port has a configured byte target for a round. The head-of-line packet length arrives over a ready/valid handshake. The block serves the ports one after another in a fixed order, so that the workers also finish their share of a round in sequence. For every accepted packet it raises a one-cycle dispatch strobe that carries the chosen port index and the packet length.

Each port keeps a signed working balance. The head packet goes to the current port when twice the balance is at least the packet length. If it does not qualify, the port closes its share of the round. Whatever is left of its balance, positive or negative, carries into that port's starting balance in the next round. After the last port the pointer wraps to port 0, and the block then holds off for a programmed number of idle cycles before the next round starts.

Targets and the idle gap sit in configuration registers. These registers accept writes only while the run enable is low. Dropping the enable also restarts the schedule from port 0 with no carried leftovers.

Top module: `batch_dispatch`

## Requirements
- R1: While `rst` is high, and while `en` is low, `pkt_ready` and `disp_valid` stay low. One cycle after `en` rises, the round starts at port 0 with a balance equal to port 0's configured target.
- R2: When `pkt_valid` is high and twice the current balance is at least `pkt_len`, `pkt_ready` is high and the packet is taken on that edge. In the next cycle `disp_valid` is high for one cycle, with `disp_port` set to the current port and `disp_len` set to the packet length. The balance then drops by the length and may go negative.
- R3: When `pkt_valid` is high and twice the balance is below `pkt_len`, `pkt_ready` stays low and nothing is dispatched. In that single cycle the pointer moves to the next port, whose balance becomes its target plus the leftover it kept from its previous round. The leftover of the port being left is stored for its next round.
- R4: Ports are visited in increasing index order, 0 to N-1, and the pointer then wraps to 0. Several ports may be skipped in consecutive cycles.
- R5: On the cycle that leaves port N-1, an idle gap of G cycles begins, where G is the gap register. `pkt_ready` is low throughout the gap. With G = 0, port 0 can accept on the very next cycle.
- R6: At the end of every round, each port's total dispatched bytes minus (rounds × target) equals the negative of its stored leftover. Its magnitude stays below 2^(LEN_W-1).
- R7: Configuration address k < N writes port k's target, and address N writes the gap (low GAP_W bits). A write takes effect only while `en` is low. A write while `en` is high is ignored.
- R8: While `pkt_valid` is low, the pointer and the balance hold and nothing is dispatched, whatever `pkt_len` shows.
- R9: Taking `en` low returns the pointer to port 0 and clears every port's stored leftover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the block idle and unlocks configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Register address: port targets 0..N-1, gap at N |
| cfg_wdata | input | CFG_W | Write data |
| pkt_valid | input | 1 | Head-of-line packet present |
| pkt_len | input | LEN_W | Head-of-line packet length in bytes |
| pkt_ready | output | 1 | Packet is taken on this edge |
| disp_valid | output | 1 | One-cycle dispatch strobe |
| disp_port | output | PTR_W | Port index of the dispatched packet |
| disp_len | output | LEN_W | Length of the dispatched packet |

## Verification
The hardest situation to reach is a carried deficit that starves a port in a later round. The stimulus sets this up deliberately. A packet is sent whose length is exactly twice the remaining balance, so it is accepted on the boundary and drives the balance deeply negative. The round then wraps with a zero gap, and on the next visit the port's loaded balance is zero, so it must hand over to the next port in a single cycle. The hand-computed packet sequence also includes consecutive skips across several ports in one stall, and two full rounds so that the cumulative bytes per port can be compared exactly against the targets.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  typedef enum logic [1:0] {
    DS_IDLE = 2'd0,
    DS_RUN  = 2'd1,
    DS_GAP  = 2'd2
  } dsp_state_e;

endpackage

// File: rtl/dsp_cfg_bank.sv
module dsp_cfg_bank #(
  parameter int NPORTS     = 4,
  parameter int CFG_W      = 16,
  parameter int GAP_W      = 8,
  parameter int ADDR_W     = 3,
  parameter int DEF_TARGET = 1024,
  parameter int DEF_GAP    = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           en,
  input  logic                           cfg_we,
  input  logic [ADDR_W-1:0]              cfg_addr,
  input  logic [CFG_W-1:0]               cfg_wdata,
  output logic [NPORTS-1:0][CFG_W-1:0]   tgt_q,
  output logic [GAP_W-1:0]               gap_q
);

  logic wr_ok;
  assign wr_ok = cfg_we && !en;

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_tgt
      logic [CFG_W-1:0] lane_q;
      always_ff @(posedge clk) begin
        if (rst)
          lane_q <= CFG_W'(DEF_TARGET);
        else if (wr_ok && cfg_addr == ADDR_W'(p))
          lane_q <= cfg_wdata;
      end
      assign tgt_q[p] = lane_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      gap_q <= GAP_W'(DEF_GAP);
    else if (wr_ok && cfg_addr == ADDR_W'(NPORTS))
      gap_q <= cfg_wdata[GAP_W-1:0];
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && en) |=> ($stable(tgt_q) && $stable(gap_q))); // R7

endmodule

// File: rtl/dsp_carry_bank.sv
module dsp_carry_bank #(
  parameter int NPORTS = 4,
  parameter int BAL_W  = 18,
  parameter int PTR_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    wr,
  input  logic [PTR_W-1:0]        wr_idx,
  input  logic signed [BAL_W-1:0] wr_val,
  input  logic [PTR_W-1:0]        rd_idx,
  output logic signed [BAL_W-1:0] rd_val
);

  logic [NPORTS-1:0][BAL_W-1:0] carry_flat;

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_lane
      logic [BAL_W-1:0] lane_q;
      always_ff @(posedge clk) begin
        if (rst || clr)
          lane_q <= '0;
        else if (wr && wr_idx == PTR_W'(p))
          lane_q <= wr_val;
      end
      assign carry_flat[p] = lane_q;
    end
  endgenerate

  assign rd_val = $signed(carry_flat[rd_idx]);

  AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (rd_val == '0)); // R9

endmodule

// File: rtl/dsp_gap_timer.sv
module dsp_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             start,
  input  logic [GAP_W-1:0] load_val,
  output logic             busy,
  output logic             last
);

  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (start)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == GAP_W'(1));

  AST_NO_WRAP_IN_GAP: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start); // R5

endmodule

// File: rtl/batch_dispatch.sv
module batch_dispatch #(
  parameter int NPORTS     = 4,
  parameter int LEN_W      = 11,
  parameter int CFG_W      = 16,
  parameter int GAP_W      = 8,
  parameter int DEF_TARGET = 1024,
  parameter int DEF_GAP    = 4,
  localparam int PTR_W     = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int ADDR_W    = $clog2(NPORTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              pkt_valid,
  input  logic [LEN_W-1:0]  pkt_len,
  output logic              pkt_ready,
  output logic              disp_valid,
  output logic [PTR_W-1:0]  disp_port,
  output logic [LEN_W-1:0]  disp_len
);
  import dsp_pkg::*;

  localparam int BAL_W    = CFG_W + 2;
  localparam int LAST     = NPORTS - 1;
  localparam int HALF_MAX = 2 ** (LEN_W - 1);

  dsp_state_e                    state_q;
  logic [PTR_W-1:0]              ptr_q;
  logic signed [BAL_W-1:0]       bal_q;

  logic [NPORTS-1:0][CFG_W-1:0]  tgt_q;
  logic [GAP_W-1:0]              gap_q;
  logic signed [BAL_W-1:0]       carry_rd;
  logic                          gap_busy;
  logic                          gap_last;

  logic                          run;
  logic                          take;
  logic                          accept;
  logic                          skip;
  logic                          wrap;
  logic                          tmr_start;
  logic [PTR_W-1:0]              nxt_ptr;
  logic signed [BAL_W:0]         bal_x2;
  logic signed [BAL_W:0]         len_w;
  logic signed [BAL_W-1:0]       len_s;
  logic signed [BAL_W-1:0]       load_nxt;
  logic signed [BAL_W-1:0]       load_first;

  dsp_cfg_bank #(
    .NPORTS(NPORTS), .CFG_W(CFG_W), .GAP_W(GAP_W), .ADDR_W(ADDR_W),
    .DEF_TARGET(DEF_TARGET), .DEF_GAP(DEF_GAP)
  ) u_cfg (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tgt_q(tgt_q), .gap_q(gap_q)
  );

  dsp_carry_bank #(
    .NPORTS(NPORTS), .BAL_W(BAL_W), .PTR_W(PTR_W)
  ) u_carry (
    .clk(clk), .rst(rst), .clr(!en), .wr(skip), .wr_idx(ptr_q),
    .wr_val(bal_q), .rd_idx(nxt_ptr), .rd_val(carry_rd)
  );

  dsp_gap_timer #(
    .GAP_W(GAP_W)
  ) u_gap (
    .clk(clk), .rst(rst), .clr(!en), .start(tmr_start), .load_val(gap_q),
    .busy(gap_busy), .last(gap_last)
  );

  // half-length test without division: 2*balance >= length
  assign len_s  = $signed({{(BAL_W-LEN_W){1'b0}}, pkt_len});
  assign len_w  = $signed({{(BAL_W+1-LEN_W){1'b0}}, pkt_len});
  assign bal_x2 = $signed({bal_q, 1'b0});
  assign take   = (bal_x2 >= len_w);

  assign run       = en && (state_q == DS_RUN);
  assign pkt_ready = run && take;
  assign accept    = pkt_valid && pkt_ready;
  assign skip      = run && pkt_valid && !take;
  assign nxt_ptr   = (ptr_q == PTR_W'(LAST)) ? '0 : ptr_q + 1'b1;
  assign wrap      = skip && (ptr_q == PTR_W'(LAST));
  assign tmr_start = wrap && (gap_q != '0);

  assign load_nxt   = $signed({2'b00, tgt_q[nxt_ptr]}) + carry_rd;
  assign load_first = $signed({2'b00, tgt_q[0]});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DS_IDLE;
      ptr_q   <= '0;
      bal_q   <= '0;
    end else if (!en) begin
      state_q <= DS_IDLE;
      ptr_q   <= '0;
    end else begin
      case (state_q)
        DS_IDLE: begin
          state_q <= DS_RUN;
          ptr_q   <= '0;
          bal_q   <= load_first;
        end
        DS_RUN: begin
          if (accept) begin
            bal_q <= bal_q - len_s;
          end else if (skip) begin
            ptr_q <= nxt_ptr;
            bal_q <= load_nxt;
            if (tmr_start)
              state_q <= DS_GAP;
          end
        end
        DS_GAP: begin
          if (gap_last || !gap_busy)
            state_q <= DS_RUN;
        end
        default: state_q <= DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_port  <= '0;
      disp_len   <= '0;
    end else begin
      disp_valid <= accept;
      if (accept) begin
        disp_port <= ptr_q;
        disp_len  <= pkt_len;
      end
    end
  end

  AST_ACCEPT_DISPATCH: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_ready) |=> (disp_valid && disp_len == $past(pkt_len)
                                   && disp_port == $past(ptr_q))); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !(pkt_valid && pkt_ready) |=> !disp_valid); // R3
  AST_PTR_ORDER: assert property (@(posedge clk) disable iff (rst)
    (ptr_q != $past(ptr_q)) |-> (ptr_q == '0 ||
                                 int'(ptr_q) == int'($past(ptr_q)) + 1)); // R4
  AST_READY_LOW_IN_GAP: assert property (@(posedge clk) disable iff (rst)
    gap_busy |-> !pkt_ready); // R5
  AST_BAL_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (state_q == DS_RUN) |-> (bal_q >= -HALF_MAX)); // R6
  AST_CARRY_BOUND: assert property (@(posedge clk) disable iff (rst)
    skip |-> (bal_q < HALF_MAX && bal_q >= -HALF_MAX)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pkt_ready && !disp_valid)); // R1
  AST_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    (en && state_q == DS_RUN && !pkt_valid) |=> ($stable(ptr_q) && $stable(bal_q))); // R8
  AST_RESTART_PTR: assert property (@(posedge clk) disable iff (rst)
    !en |=> (ptr_q == '0)); // R9

endmodule

// File: tb/tb_batch_dispatch.sv
module tb_batch_dispatch;

  localparam int NPORTS = 4;
  localparam int LEN_W  = 11;
  localparam int CFG_W  = 16;
  localparam int GAP_W  = 8;
  localparam int PTR_W  = 2;
  localparam int ADDR_W = 3;
  localparam int NVEC   = 15;

  // table: packet length, expected port, expected stall cycles
  // targets 300/200/100/400, gap 3 (two rounds, then first packet of round 3)
  localparam int VLEN   [NVEC] = '{100, 150, 200, 60, 90, 250, 130, 440, 10, 380, 50, 180, 20, 880, 5};
  localparam int VPORT  [NVEC] = '{  0,   0,   1,  2,  3,   3,   0,   0,  1,   1,  2,   2,  3,   3, 0};
  localparam int VSTALL [NVEC] = '{  0,   0,   1,  1,  1,   0,   4,   0,  1,   0,  1,   0,  1,   0, 4};
  localparam int TGT    [NPORTS] = '{300, 200, 100, 400};
  localparam int LEFT2  [NPORTS] = '{220, 190, 90, 440};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic              cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [CFG_W-1:0]  cfg_wdata = '0;
  logic              pkt_valid = 1'b0;
  logic [LEN_W-1:0]  pkt_len = '0;
  logic              pkt_ready;
  logic              disp_valid;
  logic [PTR_W-1:0]  disp_port;
  logic [LEN_W-1:0]  disp_len;

  int checks = 0;
  int fails = 0;
  int sends = 0;
  int seen = 0;
  int cyc = 0;
  int sum_port [NPORTS] = '{0, 0, 0, 0};
  bit done = 1'b0;

  always #5 clk = ~clk;

  batch_dispatch #(
    .NPORTS(NPORTS), .LEN_W(LEN_W), .CFG_W(CFG_W), .GAP_W(GAP_W)
  ) dut (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .pkt_ready(pkt_ready), .disp_valid(disp_valid), .disp_port(disp_port),
    .disp_len(disp_len)
  );

  always @(negedge clk) begin
    if (disp_valid) begin
      seen++;
      sum_port[disp_port] += int'(disp_len);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int addr, input int data);
    cfg_we = 1'b1;
    cfg_addr = ADDR_W'(addr);
    cfg_wdata = CFG_W'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // called at a negedge; returns at the negedge after the dispatch edge
  task automatic send(input int len, input int exp_port, input int exp_stall,
                      input string req);
    int stall = 0;
    pkt_valid = 1'b1;
    pkt_len = LEN_W'(len);
    #1;
    while (!pkt_ready && stall < 50) begin
      @(negedge clk);
      #1;
      stall++;
    end
    @(negedge clk);
    sends++;
    chk(disp_valid == 1'b1, req, "dispatch strobe", int'(disp_valid), 1);
    chk(int'(disp_port) == exp_port, req, "port", int'(disp_port), exp_port);
    chk(int'(disp_len) == len, req, "length", int'(disp_len), len);
    chk(stall == exp_stall, req, "stall cycles", stall, exp_stall);
    pkt_valid = 1'b0;
  endtask

  initial begin
    // R1: quiet during reset even with a qualifying packet offered
    pkt_valid = 1'b1;
    pkt_len = 11'd1;
    repeat (3) @(negedge clk);
    chk(pkt_ready == 1'b0, "R1", "ready in reset", int'(pkt_ready), 0);
    chk(disp_valid == 1'b0, "R1", "strobe in reset", int'(disp_valid), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(pkt_ready == 1'b0, "R1", "ready with en low", int'(pkt_ready), 0);
    pkt_valid = 1'b0;

    // R7: program targets and gap while idle
    for (int p = 0; p < NPORTS; p++) cfg_write(p, TGT[p]);
    cfg_write(NPORTS, 3);
    en = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: two rounds from the table
    for (int i = 0; i < NVEC; i++) begin
      if (i == NVEC - 1) begin
        #2;
        for (int p = 0; p < NPORTS; p++) begin
          chk(sum_port[p] - 2 * TGT[p] == LEFT2[p], "R6", "cumulative excess",
              sum_port[p] - 2 * TGT[p], LEFT2[p]);
          chk(sum_port[p] - 2 * TGT[p] < 1024 && sum_port[p] - 2 * TGT[p] > -1024,
              "R6", "excess bound", sum_port[p] - 2 * TGT[p], 1023);
        end
      end
      send(VLEN[i], VPORT[i], VSTALL[i], "R2/R3/R4/R5 table");
    end

    // R7: write with en high must not change port 0's target
    cfg_write(0, 5);
    // R9: restart clears the pointer and leftovers; gap set to zero
    en = 1'b0;
    cfg_write(NPORTS, 0);
    en = 1'b1;
    @(negedge clk);
    send(600, 0, 0, "R7 R9 boundary accept at full target");
    send(1, 1, 1, "R3 negative balance advances");
    send(500, 3, 2, "R4 two ports skipped in a row");
    send(700, 1, 2, "R5 zero gap and starved port");

    // R8: no valid, a rejectable length on the bus, nothing moves
    pkt_len = 11'd1000;
    begin
      int quiet = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (disp_valid) quiet++;
      end
      chk(quiet == 0, "R8", "strobes while idle", quiet, 0);
    end
    send(1, 2, 1, "R8 pointer held while idle");

    #2;
    chk(seen == sends, "R2", "total strobes", seen, sends);
    finish_run();
  end

endmodule